// File: doc/BRIEF.md
# Software Trap Entry Sequencer

This block carries out the entry sequence of a software trap in a processor core. When the core presents a trap request with a 4-bit trap number, it also supplies the current program counter, status register, active stack pointer and supervisor stack pointer. The sequencer then saves the return state on a descending stack and loads the handler address from a vector table.

Each step is one access on a simple request/acknowledge memory bus that carries word or long transfers. The program counter is pushed first, then the status register, and then the handler address is read. The sequencer holds each access until the bus acknowledges it. At the end it gives the core the handler program counter, the adjusted stack pointer, a status register with the supervisor bit forced on, and the fixed instruction cost. A done pulse marks that these results are valid, and they stay on the outputs after the pulse.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, `busy`, `done` and `bus_req` are low, and all result outputs read zero.
- R2: A request seen while idle is accepted at that clock edge. `busy` is high from the next cycle and stays high through the cycle in which `done` is high. It is low in the cycle after that.
- R3: The first bus access is a long write (`bus_we`=1, `bus_long`=1) of the request's program counter, to the base stack pointer minus 4.
- R4: The second bus access is a word write (`bus_long`=0) to the base stack pointer minus 6. Its data is the status register exactly as it was requested, with the supervisor bit not yet set, zero-extended in bits 31:16.
- R5: The third bus access is a long read (`bus_we`=0) from address (32 + trap number) × 4.
- R6: The base stack pointer is `sp_in` when status bit 13 (the supervisor bit) of the request is 1. When that bit is 0, the base is `ssp_in`.
- R7: When `done` is high, `new_pc` holds the data read in the third access and `new_sp` holds the base minus 6. `new_sr` holds the requested status register with bit 13 set, and `cost_cycles` holds 26. These values stay on the outputs until the next trap completes.
- R8: The sequencer stays in an access, with request, address, direction, size and write data unchanged, until `bus_ack` is high at a clock edge. An access that waits W cycles for acknowledge takes W+1 cycles.
- R9: A request raised while `busy` is high is ignored. It does not change the addresses, the data or the results of the trap in progress.
- R10: `done` is high for exactly one cycle per accepted request, and the block is idle again in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled while idle |
| trap_num | input | 4 | Trap number (low opcode bits) |
| pc_in | input | 32 | Program counter to return to |
| sr_in | input | 16 | Current status register, supervisor flag in bit 13 |
| sp_in | input | 32 | Currently active stack pointer |
| ssp_in | input | 32 | Supervisor stack pointer, used when entering from user mode |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_long | output | 1 | 1 = 32-bit transfer, 0 = 16-bit transfer |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes at this edge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 32 | Handler address fetched from the vector table |
| new_sp | output | 32 | Stack pointer after both pushes |
| new_sr | output | 16 | Status register with the supervisor bit set |
| cost_cycles | output | 8 | Cycle cost reported for the trap |

## Verification
The accepting edge is the first edge at which `trap_req` is seen while idle, and `busy` is due one cycle after it. With W wait cycles per access, the three accesses take 3·(W+1) cycles, so `done` is due exactly that many edges after the accepting edge. The bench counts edges from the accepting edge and checks this count for W = 0, 1, 2 and 3. It records each access at the edge where it is acknowledged and samples every output at the falling edge. In the cycle after `done`, it checks that `busy` has dropped and that the results are unchanged.

// File: rtl/trap_seq_pkg.sv
// Shared types for the trap entry sequencer.
// Assumes: nothing beyond the standard language.
package trap_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PUSH_PC = 3'd1,
        ST_PUSH_SR = 3'd2,
        ST_FETCH   = 3'd3,
        ST_DONE    = 3'd4
    } seq_state_t;
endpackage

// File: rtl/trap_frame_calc.sv
// Address arithmetic for the trap frame.
// Chooses the base stack pointer from the incoming status register
// (supervisor stack when entering from user mode). From the captured base
// it derives the two push slots, and from the captured trap number the
// vector table address.
// Assumes: the stack grows downward and addresses are byte addresses.
module trap_frame_calc #(
    parameter int ADDR_W   = 32,
    parameter int SR_W     = 16,
    parameter int NUM_W    = 4,
    parameter int S_BIT    = 13,
    parameter int VEC_BASE = 32,
    parameter int PC_BYTES = 4,
    parameter int SR_BYTES = 2
) (
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] ssp_in,
    input  logic [ADDR_W-1:0] base_q,
    input  logic [NUM_W-1:0]  num_q,
    output logic [ADDR_W-1:0] base_sel,
    output logic [ADDR_W-1:0] pc_slot,
    output logic [ADDR_W-1:0] sr_slot,
    output logic [ADDR_W-1:0] vec_addr
);
    localparam logic [ADDR_W-1:0] PC_DEC = ADDR_W'(PC_BYTES);
    localparam logic [ADDR_W-1:0] SR_DEC = ADDR_W'(PC_BYTES + SR_BYTES);
    localparam logic [ADDR_W-1:0] VBASE  = ADDR_W'(VEC_BASE);

    logic [ADDR_W-1:0] vec_num;

    // Pick the stack that the frame goes on.
    always_comb base_sel = sr_in[S_BIT] ? sp_in : ssp_in;

    // Derive frame slots and the vector entry address.
    always_comb begin
        pc_slot  = base_q - PC_DEC;
        sr_slot  = base_q - SR_DEC;
        vec_num  = VBASE + ADDR_W'(num_q);
        vec_addr = vec_num << 2;
    end
endmodule

// File: rtl/trap_ctrl_fsm.sv
// Sequencing control for trap entry.
// Steps idle -> push PC -> push SR -> fetch vector -> done -> idle.
// A bus step advances only on acknowledge, and requests are taken only
// while idle.
// Assumes: bus_ack is meaningful only while an access is requested.
module trap_ctrl_fsm
    import trap_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trap_req,
    input  logic       bus_ack,
    output seq_state_t state,
    output logic       accept,
    output logic       fetch_done
);
    seq_state_t nxt;

    // Accept and completion strobes.
    always_comb begin
        accept     = (state == ST_IDLE) && trap_req;
        fetch_done = (state == ST_FETCH) && bus_ack;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (trap_req) nxt = ST_PUSH_PC;
            ST_PUSH_PC: if (bus_ack)  nxt = ST_PUSH_SR;
            ST_PUSH_SR: if (bus_ack)  nxt = ST_FETCH;
            ST_FETCH:   if (bus_ack)  nxt = ST_DONE;
            ST_DONE:                  nxt = ST_IDLE;
            default:                  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/trap_bus_drive.sv
// Bus request generation for trap entry.
// Maps the sequencer state onto one bus access: a long PC write, a word
// SR write (zero-extended), or a long vector read.
// Assumes: all inputs are registered, so the bus outputs hold steady
// while an access waits.
module trap_bus_drive
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SR_W   = 16
) (
    input  seq_state_t        state,
    input  logic [DATA_W-1:0] pc_q,
    input  logic [SR_W-1:0]   sr_q,
    input  logic [ADDR_W-1:0] pc_slot,
    input  logic [ADDR_W-1:0] sr_slot,
    input  logic [ADDR_W-1:0] vec_addr,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_long,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    // Decode the current step into one bus access.
    always_comb begin
        bus_req   = 1'b0;
        bus_we    = 1'b0;
        bus_long  = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state)
            ST_PUSH_PC: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_long  = 1'b1;
                bus_addr  = pc_slot;
                bus_wdata = pc_q;
            end
            ST_PUSH_SR: begin
                bus_req   = 1'b1;
                bus_we    = 1'b1;
                bus_addr  = sr_slot;
                bus_wdata = DATA_W'(sr_q);
            end
            ST_FETCH: begin
                bus_req   = 1'b1;
                bus_long  = 1'b1;
                bus_addr  = vec_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_entry_seq.sv
// Trap entry sequencer top.
// On an accepted request it captures PC, SR, the chosen stack base and the
// trap number. It pushes PC then SR below the base, reads the handler
// address from the vector table, and then presents the results with a
// one-cycle done pulse.
// Assumes: a single outstanding trap, and that the core holds off further
// requests while busy (extra ones are dropped).
module trap_entry_seq
    import trap_seq_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SR_W     = 16,
    parameter int NUM_W    = 4,
    parameter int S_BIT    = 13,
    parameter int VEC_BASE = 32,
    parameter int COST     = 26,
    parameter int CYC_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic [NUM_W-1:0]  trap_num,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [SR_W-1:0]   sr_in,
    input  logic [ADDR_W-1:0] sp_in,
    input  logic [ADDR_W-1:0] ssp_in,
    output logic              bus_req,
    output logic              bus_we,
    output logic              bus_long,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_sp,
    output logic [SR_W-1:0]   new_sr,
    output logic [CYC_W-1:0]  cost_cycles
);
    localparam logic [SR_W-1:0]  S_MASK   = SR_W'(1) << S_BIT;
    localparam logic [CYC_W-1:0] COST_VAL = CYC_W'(COST);

    seq_state_t        state;
    logic              accept;
    logic              fetch_done;
    logic [DATA_W-1:0] pc_q;
    logic [SR_W-1:0]   sr_q;
    logic [ADDR_W-1:0] base_q;
    logic [NUM_W-1:0]  num_q;
    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W-1:0] pc_slot;
    logic [ADDR_W-1:0] sr_slot;
    logic [ADDR_W-1:0] vec_addr;

    trap_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trap_req   (trap_req),
        .bus_ack    (bus_ack),
        .state      (state),
        .accept     (accept),
        .fetch_done (fetch_done)
    );

    trap_frame_calc #(
        .ADDR_W   (ADDR_W),
        .SR_W     (SR_W),
        .NUM_W    (NUM_W),
        .S_BIT    (S_BIT),
        .VEC_BASE (VEC_BASE)
    ) u_calc (
        .sr_in    (sr_in),
        .sp_in    (sp_in),
        .ssp_in   (ssp_in),
        .base_q   (base_q),
        .num_q    (num_q),
        .base_sel (base_sel),
        .pc_slot  (pc_slot),
        .sr_slot  (sr_slot),
        .vec_addr (vec_addr)
    );

    trap_bus_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SR_W   (SR_W)
    ) u_bus (
        .state     (state),
        .pc_q      (pc_q),
        .sr_q      (sr_q),
        .pc_slot   (pc_slot),
        .sr_slot   (sr_slot),
        .vec_addr  (vec_addr),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_long  (bus_long),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // Capture the trap context at the accepting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q   <= '0;
            sr_q   <= '0;
            base_q <= '0;
            num_q  <= '0;
        end else if (accept) begin
            pc_q   <= pc_in;
            sr_q   <= sr_in;
            base_q <= base_sel;
            num_q  <= trap_num;
        end
    end

    // Load results when the vector read completes; hold them afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc      <= '0;
            new_sp      <= '0;
            new_sr      <= '0;
            cost_cycles <= '0;
        end else if (fetch_done) begin
            new_pc      <= bus_rdata;
            new_sp      <= sr_slot;
            new_sr      <= sr_q | S_MASK;
            cost_cycles <= COST_VAL;
        end
    end

    // Status strobes from the sequencer state.
    always_comb begin
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
    end
endmodule

// File: rtl/trap_entry_seq_chk.sv
// Protocol checker for the trap entry sequencer, attached by bind.
// Assumes: synchronous active-low reset; checks only port-level behaviour.
module trap_entry_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SR_W   = 16,
    parameter int S_BIT  = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic              bus_long,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_ack,
    input logic              busy,
    input logic              done,
    input logic [SR_W-1:0]   new_sr
);
    // R8
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_long) && $stable(bus_wdata)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R2
    done_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    // R1
    idle_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    // R7
    sr_super_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> new_sr[S_BIT]);

    // R5
    read_is_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |-> (bus_long && (bus_addr[1:0] == 2'b00)));
endmodule

bind trap_entry_seq trap_entry_seq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SR_W   (SR_W),
    .S_BIT  (S_BIT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_long  (bus_long),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .done      (done),
    .new_sr    (new_sr)
);

// File: tb/trap_entry_seq_tb_top.sv
// Directed bench for the trap entry sequencer: one task per scenario.
module trap_entry_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [3:0]  trap_num = '0;
    logic [31:0] pc_in = '0;
    logic [15:0] sr_in = '0;
    logic [31:0] sp_in = '0;
    logic [31:0] ssp_in = '0;
    logic        bus_req, bus_we, bus_long;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        busy, done;
    logic [31:0] new_pc, new_sp;
    logic [15:0] new_sr;
    logic [7:0]  cost_cycles;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // bus model state
    int          wait_states = 0;
    int          wcnt = 0;
    int          nacc = 0;
    logic [31:0] a_addr [3];
    logic [31:0] a_data [3];
    logic        a_we   [3];
    logic        a_long [3];

    always #2 clk = ~clk;

    trap_entry_seq dut_i (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_num(trap_num),
        .pc_in(pc_in), .sr_in(sr_in), .sp_in(sp_in), .ssp_in(ssp_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_long(bus_long),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .new_pc(new_pc),
        .new_sp(new_sp), .new_sr(new_sr), .cost_cycles(cost_cycles)
    );

    function automatic logic [31:0] vec_content(input logic [31:0] a);
        return 32'h00A0_0000 | (a << 4) | 32'h3;
    endfunction

    // Memory model: acknowledge after wait_states cycles, record accesses.
    always @(negedge clk) begin
        if (bus_req) begin
            if (wcnt >= wait_states) begin
                bus_ack   = 1'b1;
                bus_rdata = vec_content(bus_addr);
                wcnt      = 0;
                if (nacc < 3) begin
                    a_addr[nacc] = bus_addr;
                    a_data[nacc] = bus_wdata;
                    a_we[nacc]   = bus_we;
                    a_long[nacc] = bus_long;
                end
                nacc++;
            end else begin
                bus_ack = 1'b0;
                wcnt++;
            end
        end else begin
            bus_ack = 1'b0;
            wcnt    = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 0, "R1 busy", 32'(busy), 0);
        chk(done == 0, "R1 done", 32'(done), 0);
        chk(bus_req == 0, "R1 bus_req", 32'(bus_req), 0);
        chk(new_pc == 0 && new_sp == 0, "R1 results", new_pc, 0);
        chk(new_sr == 0 && cost_cycles == 0, "R1 sr/cost", 32'(new_sr), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Run one trap and check every result against values computed here.
    task automatic t_trap(input logic [3:0] n, input logic [31:0] pc,
                          input logic [15:0] sr, input logic [31:0] sp,
                          input logic [31:0] ssp, input int ws, input bit noise);
        logic [31:0] base, vaddr;
        int edges;
        base  = sr[13] ? sp : ssp;           // R6
        vaddr = (32'd32 + 32'(n)) * 4;
        wait_states = ws;
        nacc = 0;
        trap_num = n; pc_in = pc; sr_in = sr; sp_in = sp; ssp_in = ssp;
        trap_req = 1'b1;
        @(posedge clk);                      // accepting edge
        edges = 0;
        @(negedge clk);
        chk(busy == 1, "R2 busy after accept", 32'(busy), 1);
        if (noise) begin
            trap_req = 1'b1; trap_num = ~n; pc_in = ~pc; sr_in = ~sr;
            sp_in = sp + 32'h100; ssp_in = ssp + 32'h100;
        end else trap_req = 1'b0;
        while (!done && edges < 100) begin
            @(posedge clk); edges++;
            @(negedge clk);
            if (!done) chk(busy == 1, "R2 busy held", 32'(busy), 1);
        end
        trap_req = 1'b0;
        chk(edges == 3 * (ws + 1), "R8 done timing", 32'(edges), 32'(3 * (ws + 1)));
        chk(nacc == 3, "R8 access count", 32'(nacc), 3);
        chk(a_we[0] && a_long[0] && a_addr[0] == base - 4, "R3 pc push addr", a_addr[0], base - 4);
        chk(a_data[0] == pc, "R3 pc push data", a_data[0], pc);
        chk(a_we[1] && !a_long[1] && a_addr[1] == base - 6, "R4 sr push addr", a_addr[1], base - 6);
        chk(a_data[1] == {16'h0, sr}, "R4 sr push data", a_data[1], {16'h0, sr});
        chk(!a_we[2] && a_long[2] && a_addr[2] == vaddr, "R5 vector addr", a_addr[2], vaddr);
        chk(new_pc == vec_content(vaddr), "R7 new_pc", new_pc, vec_content(vaddr));
        chk(new_sp == base - 6, "R7 new_sp", new_sp, base - 6);
        chk(new_sr == (sr | 16'h2000), "R7 new_sr", 32'(new_sr), 32'(sr | 16'h2000));
        chk(cost_cycles == 8'd26, "R7 cost", 32'(cost_cycles), 26);
        if (noise) chk(a_addr[2] == vaddr, "R9 ignored request", a_addr[2], vaddr);
        @(negedge clk);
        chk(!done && !busy, "R10 single pulse", {30'h0, done, busy}, 0);
        chk(new_pc == vec_content(vaddr) && new_sp == base - 6, "R7 results held", new_pc,
            vec_content(vaddr));
        chk(bus_req == 0, "R10 idle bus", 32'(bus_req), 0);
    endtask

    initial begin
        t_reset();
        t_trap(4'h0, 32'h0000_1234, 16'h2700, 32'h0000_8000, 32'h0000_F000, 0, 0);
        t_trap(4'hF, 32'h00AB_CDEE, 16'h001F, 32'h0000_4000, 32'h0001_0000, 2, 0);
        t_trap(4'h7, 32'hFFFF_FFFE, 16'hA71A, 32'h0000_0006, 32'h0000_9990, 1, 0);
        t_trap(4'h3, 32'h0000_0100, 16'h0005, 32'h0000_2222, 32'h0000_7FF0, 3, 1);
        t_reset();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule